// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block holds two single-word mailbox registers that let each side of a bidirectional, dual-clock buffer pass one word to the other side without going through the FIFO queues. The forward mailbox (mail1) is written from port A and read from port B. The reverse mailbox (mail2) is written from port B and read from port A. Each writer sees a free flag. The flag drops when the writer deposits a word. It rises again only after the far side has read that word and the clear has crossed back into the writer's clock domain. While the flag is low, further deposits are refused.

Each port decodes its own control inputs: an active-low chip select, a direction input, an enable and a mailbox select. From these it produces mailbox and FIFO strobes, a read-data multiplexer choosing the mailbox or the FIFO output register, and an output-enable that stands in for a tri-state bus. The two ports read their direction input with opposite polarity. The two clocks may be unrelated, or they may be one clock. Set and clear events cross between the domains as toggles through two-flop synchronizers. Each mailbox has a synchronous active-high reset input in each domain. The two are meant to be raised together for at least four edges of each clock.

Top module: `mbx_pair`

## Requirements
- R1: While a mailbox's two reset inputs are high, the next edge forces that mailbox's writer free flag high and clears its stored word to zero.
- R2: On a clk_a edge with a_cs_n=0, a_dir=1 (write), a_en=1, a_mbx_sel=1 and m1_free_a=1, a_wdata is stored in mail1 and m1_free_a is low after that edge.
- R3: A mail1 write attempted while m1_free_a is low leaves the stored word unchanged.
- R4: A port-B mailbox read (b_cs_n=0, b_dir=1, b_en=1, b_mbx_sel=1) that clears mail1 makes m1_free_a high after the second clk_a edge following the read edge when both ports share one clock. The flag stays low after the first such edge.
- R5: A mailbox read on port B has no effect unless the stored word has already reached the port-B domain, which takes two clk_b edges after the write edge. Reads on the first and second clk_b edges after the write leave m1_free_a low. A read on the third edge clears it.
- R6: Mail2 behaves the same way in the other direction. Port B writes it with b_dir=0, port A clears it with a mailbox read (a_dir=0), and m2_free_b is its flag.
- R7: b_rdata equals mail1 when b_mbx_sel=1 and equals b_fifo_q when b_mbx_sel=0. a_rdata equals mail2 when a_mbx_sel=1 and equals a_fifo_q when a_mbx_sel=0.
- R8: a_oe is high only when a_cs_n=0 and a_dir=0. b_oe is high only when b_cs_n=0 and b_dir=1. Neither depends on the enable input.
- R9: A fifo write or read strobe is high only when its port has chip select low, the enable high, mailbox select low and the matching direction. Port A writes when a_dir=1 and reads when a_dir=0. Port B writes when b_dir=0 and reads when b_dir=1.
- R10: Resetting one mailbox leaves the other mailbox's word and flag unchanged.
- R11: Both ports may deposit into their mailboxes on the same edge, and each word arrives intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| m1_rst_a | input | 1 | Mail1 reset, clk_a domain, active high |
| m1_rst_b | input | 1 | Mail1 reset, clk_b domain, active high |
| m2_rst_a | input | 1 | Mail2 reset, clk_a domain, active high |
| m2_rst_b | input | 1 | Mail2 reset, clk_b domain, active high |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_dir | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A enable |
| a_mbx_sel | input | 1 | Port A selects mailbox (1) or FIFO (0) |
| a_wdata | input | W | Port A write data |
| a_fifo_q | input | W | Reverse FIFO output register |
| a_rdata | output | W | Port A read data |
| a_oe | output | 1 | Port A output enable |
| a_fifo_wr | output | 1 | Forward FIFO write strobe |
| a_fifo_rd | output | 1 | Reverse FIFO read strobe |
| m1_free_a | output | 1 | Mail1 can accept a word (low = occupied) |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_dir | input | 1 | Port B direction, 0 = write |
| b_en | input | 1 | Port B enable |
| b_mbx_sel | input | 1 | Port B selects mailbox (1) or FIFO (0) |
| b_wdata | input | W | Port B write data |
| b_fifo_q | input | W | Forward FIFO output register |
| b_rdata | output | W | Port B read data |
| b_oe | output | 1 | Port B output enable |
| b_fifo_wr | output | 1 | Reverse FIFO write strobe |
| b_fifo_rd | output | 1 | Forward FIFO read strobe |
| m2_free_b | output | 1 | Mail2 can accept a word (low = occupied) |

## Verification
On every cycle, the assertions check four things: an accepted deposit drops the writer flag, the stored word holds still while the flag is low, a reset edge leaves the flag high and the word zero, and no port ever raises two strobes at once. Only the bench scenarios can show the cross-domain timing. That covers the exact edges at which a clear becomes visible, early reads being ignored, and the flag rising two edges after a clear. The bench scenarios also show that a refused deposit keeps the first word, that the per-mailbox resets are isolated, and that the mux and output-enable follow each port's own direction polarity.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Raw control inputs of one port.
    typedef struct packed {
        logic cs_n;
        logic dir;
        logic en;
        logic mbx;
    } port_ctl_t;

    // Decoded operation of one port.
    typedef struct packed {
        logic oe;
        logic mb_wr;
        logic mb_rd;
        logic fifo_wr;
        logic fifo_rd;
    } port_op_t;

    localparam int unsigned SYNC_STAGES = 2;

    // wr_level: value of dir that means "write" on this port.
    function automatic port_op_t decode_op(port_ctl_t c, logic wr_level);
        port_op_t o;
        logic     is_wr;
        logic     go;
        is_wr     = (c.dir == wr_level);
        go        = !c.cs_n && c.en;
        o.oe      = !c.cs_n && !is_wr;
        o.mb_wr   = go && is_wr && c.mbx;
        o.mb_rd   = go && !is_wr && c.mbx;
        o.fifo_wr = go && is_wr && !c.mbx;
        o.fifo_rd = go && !is_wr && !c.mbx;
        return o;
    endfunction

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
    import mbx_pkg::*;
#(
    parameter bit WR_LEVEL = 1'b1
) (
    input  port_ctl_t ctl,
    output port_op_t  op
);

    assign op = decode_op(ctl, WR_LEVEL);

endmodule

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/mbx_lane.sv
// One mailbox direction: word store and free flag in the writer domain,
// clear logic in the reader domain, toggles crossing both ways.
module mbx_lane
    import mbx_pkg::*;
#(
    parameter int unsigned W = 36
) (
    input  logic         wclk,
    input  logic         wrst,
    input  logic         rclk,
    input  logic         rrst,
    input  logic         wr_req,
    input  logic         rd_req,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] word,
    output logic         wr_free
);

    logic wr_tgl;
    logic rd_tgl;
    logic rd_tgl_w;   // reader toggle seen in writer domain
    logic wr_tgl_r;   // writer toggle seen in reader domain
    logic [W-1:0] store;
    logic accept;
    logic held_r;

    assign wr_free = (wr_tgl == rd_tgl_w);
    assign accept  = wr_req && wr_free;
    assign held_r  = (wr_tgl_r != rd_tgl);

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wr_tgl <= 1'b0;
            store  <= '0;
        end else if (accept) begin
            wr_tgl <= ~wr_tgl;
            store  <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst)                  rd_tgl <= 1'b0;
        else if (rd_req && held_r) rd_tgl <= ~rd_tgl;
    end

    mbx_sync #(.STAGES(SYNC_STAGES)) i_to_rd (
        .clk(rclk), .rst(rrst), .d(wr_tgl), .q(wr_tgl_r)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) i_to_wr (
        .clk(wclk), .rst(wrst), .d(rd_tgl), .q(rd_tgl_w)
    );

    assign word = store;

endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int unsigned W = 36
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         m1_rst_a,
    input  logic         m1_rst_b,
    input  logic         m2_rst_a,
    input  logic         m2_rst_b,
    input  logic         a_cs_n,
    input  logic         a_dir,
    input  logic         a_en,
    input  logic         a_mbx_sel,
    input  logic [W-1:0] a_wdata,
    input  logic [W-1:0] a_fifo_q,
    output logic [W-1:0] a_rdata,
    output logic         a_oe,
    output logic         a_fifo_wr,
    output logic         a_fifo_rd,
    output logic         m1_free_a,
    input  logic         b_cs_n,
    input  logic         b_dir,
    input  logic         b_en,
    input  logic         b_mbx_sel,
    input  logic [W-1:0] b_wdata,
    input  logic [W-1:0] b_fifo_q,
    output logic [W-1:0] b_rdata,
    output logic         b_oe,
    output logic         b_fifo_wr,
    output logic         b_fifo_rd,
    output logic         m2_free_b
);

    port_ctl_t ctl_a, ctl_b;
    port_op_t  op_a, op_b;
    logic [W-1:0] m1_word, m2_word;

    assign ctl_a = '{cs_n: a_cs_n, dir: a_dir, en: a_en, mbx: a_mbx_sel};
    assign ctl_b = '{cs_n: b_cs_n, dir: b_dir, en: b_en, mbx: b_mbx_sel};

    // Port A writes on dir high, port B writes on dir low.
    mbx_port_dec #(.WR_LEVEL(1'b1)) i_dec_a (.ctl(ctl_a), .op(op_a));
    mbx_port_dec #(.WR_LEVEL(1'b0)) i_dec_b (.ctl(ctl_b), .op(op_b));

    mbx_lane #(.W(W)) i_mail1 (
        .wclk(clk_a), .wrst(m1_rst_a), .rclk(clk_b), .rrst(m1_rst_b),
        .wr_req(op_a.mb_wr), .rd_req(op_b.mb_rd),
        .wdata(a_wdata), .word(m1_word), .wr_free(m1_free_a)
    );

    mbx_lane #(.W(W)) i_mail2 (
        .wclk(clk_b), .wrst(m2_rst_b), .rclk(clk_a), .rrst(m2_rst_a),
        .wr_req(op_b.mb_wr), .rd_req(op_a.mb_rd),
        .wdata(b_wdata), .word(m2_word), .wr_free(m2_free_b)
    );

    assign a_rdata   = a_mbx_sel ? m2_word : a_fifo_q;
    assign b_rdata   = b_mbx_sel ? m1_word : b_fifo_q;
    assign a_oe      = op_a.oe;
    assign b_oe      = op_b.oe;
    assign a_fifo_wr = op_a.fifo_wr;
    assign a_fifo_rd = op_a.fifo_rd;
    assign b_fifo_wr = op_b.fifo_wr;
    assign b_fifo_rd = op_b.fifo_rd;

endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
    parameter int unsigned W = 36
) (
    input logic         clk_a,
    input logic         clk_b,
    input logic         m1_rst_a,
    input logic         m2_rst_b,
    input logic         a_mb_wr,
    input logic         b_mb_wr,
    input logic         a_fifo_wr,
    input logic         a_fifo_rd,
    input logic         b_fifo_wr,
    input logic         b_fifo_rd,
    input logic         m1_free_a,
    input logic         m2_free_b,
    input logic [W-1:0] m1_word,
    input logic [W-1:0] m2_word
);

    // R2
    m1_take_chk: assert property (@(posedge clk_a) disable iff (m1_rst_a)
        (a_mb_wr && m1_free_a) |=> !m1_free_a);

    // R6
    m2_take_chk: assert property (@(posedge clk_b) disable iff (m2_rst_b)
        (b_mb_wr && m2_free_b) |=> !m2_free_b);

    // R3
    m1_hold_chk: assert property (@(posedge clk_a) disable iff (m1_rst_a)
        !m1_free_a |=> $stable(m1_word));

    // R6
    m2_hold_chk: assert property (@(posedge clk_b) disable iff (m2_rst_b)
        !m2_free_b |=> $stable(m2_word));

    // R1
    m1_reset_chk: assert property (@(posedge clk_a)
        $past(m1_rst_a) |-> (m1_free_a && m1_word == '0));

    // R1
    m2_reset_chk: assert property (@(posedge clk_b)
        $past(m2_rst_b) |-> (m2_free_b && m2_word == '0));

    // R9
    a_strobe_chk: assert property (@(posedge clk_a)
        $onehot0({a_fifo_wr, a_fifo_rd, a_mb_wr}));

    // R9
    b_strobe_chk: assert property (@(posedge clk_b)
        $onehot0({b_fifo_wr, b_fifo_rd, b_mb_wr}));

endmodule

bind mbx_pair mbx_pair_chk #(.W(W)) i_chk (
    .clk_a(clk_a), .clk_b(clk_b), .m1_rst_a(m1_rst_a), .m2_rst_b(m2_rst_b),
    .a_mb_wr(op_a.mb_wr), .b_mb_wr(op_b.mb_wr),
    .a_fifo_wr(a_fifo_wr), .a_fifo_rd(a_fifo_rd),
    .b_fifo_wr(b_fifo_wr), .b_fifo_rd(b_fifo_rd),
    .m1_free_a(m1_free_a), .m2_free_b(m2_free_b),
    .m1_word(m1_word), .m2_word(m2_word)
);

// File: tb/test_mbx_pair.sv
module test_mbx_pair;

    localparam int W = 36;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic m1_rst_a, m1_rst_b, m2_rst_a, m2_rst_b;
    logic a_cs_n, a_dir, a_en, a_mbx_sel;
    logic b_cs_n, b_dir, b_en, b_mbx_sel;
    logic [W-1:0] a_wdata, a_fifo_q, a_rdata, b_wdata, b_fifo_q, b_rdata;
    logic a_oe, a_fifo_wr, a_fifo_rd, m1_free_a;
    logic b_oe, b_fifo_wr, b_fifo_rd, m2_free_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    mbx_pair #(.W(W)) i_mbx_pair (
        .clk_a(clk), .clk_b(clk),
        .m1_rst_a(m1_rst_a), .m1_rst_b(m1_rst_b),
        .m2_rst_a(m2_rst_a), .m2_rst_b(m2_rst_b),
        .a_cs_n(a_cs_n), .a_dir(a_dir), .a_en(a_en), .a_mbx_sel(a_mbx_sel),
        .a_wdata(a_wdata), .a_fifo_q(a_fifo_q), .a_rdata(a_rdata), .a_oe(a_oe),
        .a_fifo_wr(a_fifo_wr), .a_fifo_rd(a_fifo_rd), .m1_free_a(m1_free_a),
        .b_cs_n(b_cs_n), .b_dir(b_dir), .b_en(b_en), .b_mbx_sel(b_mbx_sel),
        .b_wdata(b_wdata), .b_fifo_q(b_fifo_q), .b_rdata(b_rdata), .b_oe(b_oe),
        .b_fifo_wr(b_fifo_wr), .b_fifo_rd(b_fifo_rd), .m2_free_b(m2_free_b)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_a();
        a_cs_n = 1'b1; a_dir = 1'b0; a_en = 1'b0; a_mbx_sel = 1'b0;
    endtask

    task automatic idle_b();
        b_cs_n = 1'b1; b_dir = 1'b1; b_en = 1'b0; b_mbx_sel = 1'b0;
    endtask

    task automatic a_mail_wr(input logic [W-1:0] d);
        a_cs_n = 1'b0; a_dir = 1'b1; a_en = 1'b1; a_mbx_sel = 1'b1; a_wdata = d;
    endtask

    task automatic a_mail_rd();
        a_cs_n = 1'b0; a_dir = 1'b0; a_en = 1'b1; a_mbx_sel = 1'b1;
    endtask

    task automatic b_mail_wr(input logic [W-1:0] d);
        b_cs_n = 1'b0; b_dir = 1'b0; b_en = 1'b1; b_mbx_sel = 1'b1; b_wdata = d;
    endtask

    task automatic b_mail_rd();
        b_cs_n = 1'b0; b_dir = 1'b1; b_en = 1'b1; b_mbx_sel = 1'b1;
    endtask

    task automatic pulse_reset(input bit r1, input bit r2);
        m1_rst_a = r1; m1_rst_b = r1; m2_rst_a = r2; m2_rst_b = r2;
        repeat (4) step();
        m1_rst_a = 1'b0; m1_rst_b = 1'b0; m2_rst_a = 1'b0; m2_rst_b = 1'b0;
    endtask

    task automatic t_reset();
        idle_a(); idle_b();
        a_wdata = '0; b_wdata = '0; a_fifo_q = '0; b_fifo_q = '0;
        pulse_reset(1'b1, 1'b1);
        chk("R1 m1_free_a after reset", m1_free_a, 1);
        chk("R1 m2_free_b after reset", m2_free_b, 1);
        b_mbx_sel = 1'b1; a_mbx_sel = 1'b1;
        #0.5;
        chk("R1 mail1 cleared", b_rdata, '0);
        chk("R1 mail2 cleared", a_rdata, '0);
        idle_a(); idle_b();
    endtask

    // Write mail1, reads before the word crosses are ignored, timed clear.
    task automatic t_mail1_timing();
        logic [W-1:0] d = 36'h9_A5C3_1E7F;
        a_mail_wr(d);
        step();                       // write edge E0
        idle_a();
        chk("R2 m1_free_a low after write", m1_free_a, 0);
        b_mail_rd();
        step();                       // E1: read ignored
        chk("R5 early read at E1 ignored", m1_free_a, 0);
        step();                       // E2: read ignored
        chk("R5 early read at E2 ignored", m1_free_a, 0);
        chk("R7 b_rdata shows mail1", b_rdata, d);
        step();                       // E3: read clears
        idle_b();
        chk("R4 flag still low right after clear", m1_free_a, 0);
        step();
        chk("R4 flag low one edge after clear", m1_free_a, 0);
        step();
        chk("R4 flag high two edges after clear", m1_free_a, 1);
    endtask

    task automatic t_inhibit();
        logic [W-1:0] x = 36'h1_2345_6789;
        logic [W-1:0] y = 36'hF_EDCB_A987;
        a_mail_wr(x);
        step();
        a_mail_wr(y);
        step();
        a_mail_wr(y);
        step();
        idle_a();
        b_mbx_sel = 1'b1;
        #0.5;
        chk("R3 refused write keeps first word", b_rdata, x);
        step();
        b_mail_rd();
        step();
        idle_b();
        repeat (2) step();
        chk("R3 flag freed after clear", m1_free_a, 1);
        b_mbx_sel = 1'b1;
        #0.5;
        chk("R3 word kept after clear", b_rdata, x);
        idle_b();
    endtask

    task automatic t_mail2();
        logic [W-1:0] d = 36'h5_0F0F_33CC;
        // port B with dir high is a read: must not deposit
        b_cs_n = 1'b0; b_dir = 1'b1; b_en = 1'b1; b_mbx_sel = 1'b1; b_wdata = d;
        step();
        idle_b();
        chk("R6 dir high on port B does not write", m2_free_b, 1);
        b_mail_wr(d);
        step();
        idle_b();
        chk("R6 m2_free_b low after write", m2_free_b, 0);
        step(); step();
        a_mail_rd();
        #0.5;
        chk("R7 a_rdata shows mail2", a_rdata, d);
        step();
        idle_a();
        chk("R6 flag low right after clear", m2_free_b, 0);
        step();
        chk("R6 flag low one edge after clear", m2_free_b, 0);
        step();
        chk("R6 flag high two edges after clear", m2_free_b, 1);
    endtask

    task automatic t_mux_oe();
        a_fifo_q = 36'hA_AAAA_0001; b_fifo_q = 36'hB_BBBB_0002;
        a_cs_n = 1'b0; a_dir = 1'b0; a_en = 1'b0; a_mbx_sel = 1'b0;
        b_cs_n = 1'b0; b_dir = 1'b1; b_en = 1'b0; b_mbx_sel = 1'b0;
        #0.5;
        chk("R7 a_rdata shows fifo", a_rdata, 36'hA_AAAA_0001);
        chk("R7 b_rdata shows fifo", b_rdata, 36'hB_BBBB_0002);
        chk("R8 a_oe on read without enable", a_oe, 1);
        chk("R8 b_oe on read without enable", b_oe, 1);
        a_dir = 1'b1; b_dir = 1'b0;
        #0.5;
        chk("R8 a_oe off when writing", a_oe, 0);
        chk("R8 b_oe off when writing", b_oe, 0);
        a_dir = 1'b0; b_dir = 1'b1; a_cs_n = 1'b1; b_cs_n = 1'b1;
        #0.5;
        chk("R8 a_oe off when deselected", a_oe, 0);
        chk("R8 b_oe off when deselected", b_oe, 0);
        idle_a(); idle_b();
        step();
    endtask

    task automatic t_strobes();
        a_cs_n = 1'b0; a_dir = 1'b1; a_en = 1'b1; a_mbx_sel = 1'b0;
        b_cs_n = 1'b0; b_dir = 1'b1; b_en = 1'b1; b_mbx_sel = 1'b0;
        #0.5;
        chk("R9 a_fifo_wr", {a_fifo_wr, a_fifo_rd}, 2'b10);
        chk("R9 b_fifo_rd", {b_fifo_wr, b_fifo_rd}, 2'b01);
        a_dir = 1'b0; b_dir = 1'b0;
        #0.5;
        chk("R9 a_fifo_rd", {a_fifo_wr, a_fifo_rd}, 2'b01);
        chk("R9 b_fifo_wr", {b_fifo_wr, b_fifo_rd}, 2'b10);
        a_en = 1'b0; b_en = 1'b0;
        #0.5;
        chk("R9 no A strobe without enable", {a_fifo_wr, a_fifo_rd}, 2'b00);
        chk("R9 no B strobe without enable", {b_fifo_wr, b_fifo_rd}, 2'b00);
        a_en = 1'b1; b_en = 1'b1; a_cs_n = 1'b1; b_cs_n = 1'b1;
        #0.5;
        chk("R9 no strobes when deselected", {a_fifo_wr, a_fifo_rd, b_fifo_wr, b_fifo_rd}, 4'b0000);
        idle_a(); idle_b();
        step();
    endtask

    // Same-edge deposits both ways, then reset only mail1.
    task automatic t_isolation();
        logic [W-1:0] p = 36'h3_1111_2222;
        logic [W-1:0] q = 36'hC_4444_5555;
        a_mail_wr(p);
        b_mail_wr(q);
        step();
        idle_a(); idle_b();
        chk("R11 both flags low after same-edge writes", {m1_free_a, m2_free_b}, 2'b00);
        b_mbx_sel = 1'b1; a_mbx_sel = 1'b1;
        #0.5;
        chk("R11 mail1 word intact", b_rdata, p);
        chk("R11 mail2 word intact", a_rdata, q);
        idle_a(); idle_b();
        pulse_reset(1'b1, 1'b0);
        chk("R10 mail1 flag high after its reset", m1_free_a, 1);
        chk("R10 mail2 flag untouched", m2_free_b, 0);
        b_mbx_sel = 1'b1; a_mbx_sel = 1'b1;
        #0.5;
        chk("R10 mail1 cleared by its reset", b_rdata, '0);
        chk("R10 mail2 word untouched", a_rdata, q);
        idle_a(); idle_b();
        step();
        a_mail_rd();
        step();
        idle_a();
        repeat (2) step();
        chk("R10 mail2 still clears normally", m2_free_b, 1);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        m1_rst_a = 1'b1; m1_rst_b = 1'b1; m2_rst_a = 1'b1; m2_rst_b = 1'b1;
        idle_a(); idle_b();
        a_wdata = '0; b_wdata = '0; a_fifo_q = '0; b_fifo_q = '0;
        step();
        t_reset();
        t_mail1_timing();
        t_inhibit();
        t_mail2();
        t_mux_oe();
        t_strobes();
        t_isolation();
        repeat (3) step();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            report();
            $finish;
        end
    end

endmodule